// File: doc/BRIEF.md
# Retry-aware data tenure controller

This block is the bus-master side of a split address/data bus. It follows the data tenure that each address transaction implies and decides what an address-retry snoop response does to that tenure. A transfer-start strobe queues an implied data request. A data bus grant turns the queued request into the active tenure, and the block then raises bus-busy. Transfer-acknowledge strobes deliver the beats of the burst. Each accepted beat is either committed or cancelled, depending on when it arrived relative to the snoop response window of its own address.

The window opens a programmable number of cycles after the transfer-start strobe. Its length is one cycle: the address-retry strobe counts only in that cycle. An address retry may arrive before the request has been granted. In that case it withdraws the request, and no data is ever expected for that address. If the tenure already owns the bus, the retry cancels every beat that is still open to cancellation, drops bus-busy and cuts the burst short. A mode input selects streaming timing, in which an acknowledge in the cycle just before the window is illegal and is flagged. The block holds two slots, a queued request and the active tenure, each with its own window timer. A retry aimed at a newer address therefore leaves an older tenure alone, and that tenure runs to completion.

Top module: `retry_data_tenure`

## Requirements
- R1: While and after reset, bus_busy, commit_cnt and every pulse output are 0, and no request is queued.
- R2: A transfer-start while no request is queued queues one. A grant while a request is queued and the bus is idle raises bus_busy in the next cycle. A grant with no queued request is ignored.
- R3: An acknowledge while bus_busy is high gives a beat_acc pulse in the next cycle. An acknowledge is ignored while bus_busy is low, and also while committed plus unresolved beats already equal the burst length.
- R4: The window begins W cycles after the transfer-start, where W is win_ofs. A beat acknowledged at W-2 or earlier, or after W, commits. A beat acknowledged at W-1 or at W commits only if no address-retry comes at W. A commit shows as a beat_commit pulse and a commit_cnt increment in the second cycle after the acknowledge, unless a data-retry came in between. bus_busy falls in the same cycle as the commit of the final beat.
- R5: With an address-retry at W, a beat acknowledged at W-1 is cancelled and gives a beat_cancel pulse at W+1.
- R6: With an address-retry at W, a beat acknowledged at W is cancelled and gives a beat_cancel pulse at W+1. Acknowledges from W+1 onward are ignored.
- R7: An address-retry at W while the tenure holds the bus drops bus_busy at W+1. Beats already committed remain counted in commit_cnt.
- R8: An address-retry at W of a request that has not been granted gives a req_withdrawn pulse at W+1 and discards the request. A later grant then leaves bus_busy low.
- R9: With fast_mode=1, an acknowledge at W-1 gives a proto_err pulse in the next cycle, and the beat stays cancellable. With fast_mode=0, proto_err stays 0.
- R10: An address-retry at any cycle other than a live window of a slot has no effect.
- R11: An address-retry in the window of a newer queued address leaves the active older tenure unchanged: its beats keep committing and bus_busy stays high until that tenure completes.
- R12: A data-retry in the cycle after a beat drops that beat without a cancel pulse. The tenure then needs one more acknowledge.
- R13: A win_ofs below 2 acts as 2. A burst_len of 0 acts as 1, and a burst_len above MAX_BURST acts as MAX_BURST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | 1 selects streaming timing |
| win_ofs | input | OFS_W | Cycles from transfer-start to the snoop window |
| burst_len | input | LEN_W | Beats per tenure, latched at grant |
| tstart | input | 1 | Transfer-start strobe of a new address |
| dgrant | input | 1 | Data bus grant |
| xack | input | 1 | Transfer acknowledge, one beat |
| dretry | input | 1 | Data retry for the previous beat |
| aretry | input | 1 | Address-retry snoop response |
| bus_busy | output | 1 | Active tenure owns the data bus |
| beat_acc | output | 1 | A beat was accepted last cycle |
| beat_commit | output | 1 | A beat became final |
| commit_cnt | output | LEN_W | Committed beats of the current tenure |
| beat_cancel | output | 1 | Accepted beats were cancelled by address-retry |
| req_withdrawn | output | 1 | Queued implied request was withdrawn |
| proto_err | output | 1 | Acknowledge at the forbidden streaming cycle |

## Verification
A window timer that is off by one moves the commit/cancel boundary by one beat. That error appears as a beat_commit where a beat_cancel was due, or the other way round, no later than one cycle after the window. A stale beat in the resolution stage shows two cycles after its acknowledge, as an extra commit or as a bus_busy that stays high too long. If the two slots are mixed up, a retry of a newer address either kills the older tenure or fails to pulse req_withdrawn. The bench sweeps every window offset, acknowledge position, mode and retry choice of a small configuration. It compares every output in every cycle, so any such fault shows within three cycles.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
   typedef enum logic [1:0] {
      POS_EARLY = 2'd0,
      POS_PRE   = 2'd1,
      POS_WIN   = 2'd2,
      POS_LATE  = 2'd3
   } win_pos_e;

   localparam int SLOT_Q = 0;
   localparam int SLOT_D = 1;
   localparam int N_SLOT = 2;
endpackage

// File: rtl/rdt_sat_timer.sv
module rdt_sat_timer #(
   parameter int TW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [TW-1:0] ld_val,
   output logic [TW-1:0] tval
);
   localparam logic [TW-1:0] TMAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tval <= TMAX;
      else if (ld)
         tval <= ld_val;
      else if (tval != TMAX)
         tval <= tval + 1'b1;
   end
endmodule

// File: rtl/rdt_win_pos.sv
module rdt_win_pos
   import rdt_pkg::*;
#(
   parameter int TW = 5
) (
   input  logic [TW-1:0] tval,
   input  logic [TW-1:0] wbeg,
   output win_pos_e      pos
);
   logic [TW:0] tnext;
   assign tnext = {1'b0, tval} + 1'b1;

   always_comb begin
      if (tval == wbeg)
         pos = POS_WIN;
      else if (tnext == {1'b0, wbeg})
         pos = POS_PRE;
      else if (tval < wbeg)
         pos = POS_EARLY;
      else
         pos = POS_LATE;
   end
endmodule

// File: rtl/rdt_beat_stage.sv
module rdt_beat_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic take_pre,
   input  logic dretry,
   input  logic art_now,
   output logic res_commit,
   output logic res_cancel,
   output logic pend
);
   logic st_v;
   logic st_pre;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_v   <= 1'b0;
         st_pre <= 1'b0;
      end else begin
         st_v   <= take;
         st_pre <= take & take_pre;
      end
   end

   assign pend       = st_v;
   assign res_commit = st_v & ~dretry & ~(st_pre & art_now);
   assign res_cancel = st_v & ~dretry & st_pre & art_now;
endmodule

// File: rtl/retry_data_tenure.sv
module retry_data_tenure
   import rdt_pkg::*;
#(
   parameter int OFS_W     = 4,
   parameter int MAX_BURST = 4,
   parameter bit ERR_CHECK = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           fast_mode,
   input  logic [OFS_W-1:0]               win_ofs,
   input  logic [$clog2(MAX_BURST+1)-1:0] burst_len,
   input  logic                           tstart,
   input  logic                           dgrant,
   input  logic                           xack,
   input  logic                           dretry,
   input  logic                           aretry,
   output logic                           bus_busy,
   output logic                           beat_acc,
   output logic                           beat_commit,
   output logic [$clog2(MAX_BURST+1)-1:0] commit_cnt,
   output logic                           beat_cancel,
   output logic                           req_withdrawn,
   output logic                           proto_err
);
   localparam int LEN_W = $clog2(MAX_BURST + 1);
   localparam int TW    = OFS_W + 1;
   localparam logic [TW-1:0]    TMAX    = '1;
   localparam logic [TW-1:0]    W_MIN   = TW'(2);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BURST);

   if (OFS_W < 2) begin : g_bad_ofs
      $error("OFS_W must be at least 2");
   end
   if (MAX_BURST < 1) begin : g_bad_burst
      $error("MAX_BURST must be at least 1");
   end

   // effective configuration
   logic [TW-1:0]    eff_w;
   logic [LEN_W-1:0] eff_len;
   assign eff_w   = (win_ofs < OFS_W'(2)) ? W_MIN : TW'(win_ofs);
   assign eff_len = (burst_len == '0)      ? LEN_W'(1) :
                    (burst_len > LEN_MAX)  ? LEN_MAX   : burst_len;

   // slot state
   logic             q_v;
   logic             d_v;
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] d_len;

   logic             t_ld  [N_SLOT];
   logic [TW-1:0]    t_ldv [N_SLOT];
   logic [TW-1:0]    t_val [N_SLOT];
   win_pos_e         pos   [N_SLOT];

   for (genvar gi = 0; gi < N_SLOT; gi++) begin : g_slot
      rdt_sat_timer #(.TW(TW)) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld     (t_ld[gi]),
         .ld_val (t_ldv[gi]),
         .tval   (t_val[gi])
      );
      rdt_win_pos #(.TW(TW)) u_pos (
         .tval (t_val[gi]),
         .wbeg (eff_w),
         .pos  (pos[gi])
      );
   end

   logic q_take, q_art, d_art, grant;
   assign q_take = tstart & ~q_v;
   assign q_art  = q_v & aretry & (pos[SLOT_Q] == POS_WIN);
   assign d_art  = d_v & aretry & (pos[SLOT_D] == POS_WIN);
   assign grant  = dgrant & q_v & ~d_v & ~q_art;

   assign t_ld[SLOT_Q]  = q_take;
   assign t_ldv[SLOT_Q] = TW'(1);
   assign t_ld[SLOT_D]  = grant;
   assign t_ldv[SLOT_D] = (t_val[SLOT_Q] == TMAX) ? TMAX : t_val[SLOT_Q] + 1'b1;

   // beat acceptance and resolution
   logic             pend, res_commit, res_cancel, ta_acc, cur_cancel;
   logic [LEN_W:0]   inflight;
   logic [LEN_W:0]   cnt_inc;

   assign inflight   = {1'b0, cnt} + (LEN_W+1)'(pend);
   assign cnt_inc    = {1'b0, cnt} + 1'b1;
   assign ta_acc     = d_v & xack & (inflight < {1'b0, d_len});
   assign cur_cancel = ta_acc & d_art;

   rdt_beat_stage u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (ta_acc & ~d_art),
      .take_pre   (pos[SLOT_D] == POS_PRE),
      .dretry     (dretry),
      .art_now    (d_art),
      .res_commit (res_commit),
      .res_cancel (res_cancel),
      .pend       (pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_v           <= 1'b0;
         d_v           <= 1'b0;
         cnt           <= '0;
         d_len         <= LEN_W'(1);
         beat_acc      <= 1'b0;
         beat_commit   <= 1'b0;
         beat_cancel   <= 1'b0;
         req_withdrawn <= 1'b0;
      end else begin
         if (q_take)
            q_v <= 1'b1;
         else if (grant || q_art)
            q_v <= 1'b0;

         if (grant) begin
            d_v   <= 1'b1;
            cnt   <= '0;
            d_len <= eff_len;
         end else begin
            if (res_commit)
               cnt <= cnt_inc[LEN_W-1:0];
            if (d_art)
               d_v <= 1'b0;
            else if (res_commit && cnt_inc == {1'b0, d_len})
               d_v <= 1'b0;
         end

         beat_acc      <= ta_acc;
         beat_commit   <= res_commit;
         beat_cancel   <= res_cancel | cur_cancel;
         req_withdrawn <= q_art;
      end
   end

   assign bus_busy   = d_v;
   assign commit_cnt = cnt;

   if (ERR_CHECK) begin : g_err
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            proto_err <= 1'b0;
         else
            proto_err <= ta_acc & fast_mode & (pos[SLOT_D] == POS_PRE);
      end

      assert_err_fast_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
         proto_err |-> ($past(fast_mode) && $past(bus_busy)));
   end else begin : g_noerr
      assign proto_err = 1'b0;
   end

   assert_beat_needs_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      beat_acc |-> $past(bus_busy));

   assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_cnt <= d_len);

   assert_commit_cancel_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({beat_commit, beat_cancel}));

   assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      d_art |=> !bus_busy);

   assert_withdraw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      q_art |=> (req_withdrawn && !q_v));

   assert_older_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (q_art && d_v && !res_commit) |=> bus_busy);
endmodule

// File: tb/retry_data_tenure_test.sv
module retry_data_tenure_test;
   localparam int OFS_W     = 4;
   localparam int MAX_BURST = 4;
   localparam int LEN_W     = $clog2(MAX_BURST + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             fast_mode = 1'b0;
   logic [OFS_W-1:0] win_ofs = 4'd2;
   logic [LEN_W-1:0] burst_len = 3'd1;
   logic             tstart = 1'b0, dgrant = 1'b0, xack = 1'b0;
   logic             dretry = 1'b0, aretry = 1'b0;
   logic             bus_busy, beat_acc, beat_commit, beat_cancel;
   logic             req_withdrawn, proto_err;
   logic [LEN_W-1:0] commit_cnt;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   retry_data_tenure #(.OFS_W(OFS_W), .MAX_BURST(MAX_BURST)) uut (
      .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .win_ofs(win_ofs),
      .burst_len(burst_len), .tstart(tstart), .dgrant(dgrant), .xack(xack),
      .dretry(dretry), .aretry(aretry), .bus_busy(bus_busy), .beat_acc(beat_acc),
      .beat_commit(beat_commit), .commit_cnt(commit_cnt), .beat_cancel(beat_cancel),
      .req_withdrawn(req_withdrawn), .proto_err(proto_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle_in();
      tstart = 0; dgrant = 0; xack = 0; dretry = 0; aretry = 0;
   endtask

   // one tenure, back-to-back beats from tst, optional address-retry at W
   task automatic run_scen(input int w, input bit fm, input int len, input int tst, input bit art);
      int W, L, e_nat, e_end, cntx;
      bit act;
      W = (w < 2) ? 2 : w;
      L = (len == 0) ? 1 : len;
      e_nat = tst + L + 1;
      act = art && (W < e_nat);
      e_end = act ? W + 1 : e_nat;
      fast_mode = fm; win_ofs = OFS_W'(w); burst_len = LEN_W'(len);
      for (int t = 0; t <= e_end + 3; t++) begin
         @(negedge clk);
         if (t >= 1) begin
            int ta1, ta2;
            bit b1, b2, acc1, com2, can, err1;
            ta1 = t - 1; ta2 = t - 2;
            b1 = (ta1 >= tst) && (ta1 < tst + L);
            b2 = (ta2 >= tst) && (ta2 < tst + L);
            acc1 = b1 && (!act || ta1 <= W);
            com2 = b2 && (!act || ta2 <= W - 2);
            can  = act && (t == W + 1) &&
                   (((W >= tst) && (W < tst + L)) || ((W - 1 >= tst) && (W - 1 < tst + L)));
            err1 = fm && acc1 && (ta1 == W - 1);
            chk("R2 R7 bus_busy", bus_busy, (t >= 2 && t < e_end));
            chk("R3 R6 beat_acc", beat_acc, acc1);
            chk("R4 beat_commit", beat_commit, com2);
            chk("R5 R6 beat_cancel", beat_cancel, can);
            chk("R9 proto_err", proto_err, err1);
            chk("R10 req_withdrawn", req_withdrawn, 0);
            if (t >= 2) begin
               cntx = 0;
               for (int b = tst; b < tst + L; b++)
                  if (b + 2 <= t && (!act || b <= W - 2)) cntx++;
               chk("R4 R7 commit_cnt", commit_cnt, cntx);
            end
         end
         tstart = (t == 0);
         dgrant = (t == 1);
         xack   = (t >= tst) && (t < tst + L);
         aretry = art && (t == W);
         dretry = 0;
      end
      idle_in();
      @(negedge clk);
   endtask

   initial begin
      idle_in();
      repeat (3) @(negedge clk);
      chk("R1 bus_busy", bus_busy, 0);
      chk("R1 commit_cnt", commit_cnt, 0);
      chk("R1 pulses", {beat_acc, beat_commit, beat_cancel, req_withdrawn, proto_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1 busy after reset", bus_busy, 0);

      // sweep: offsets (1 maps to 2, R13), modes, retry, lengths, beat start
      for (int w = 1; w <= 5; w++)
         for (int fm = 0; fm < 2; fm++)
            for (int art = 0; art < 2; art++)
               for (int li = 0; li < 2; li++) begin
                  int wl;
                  wl = (w < 2) ? 2 : w;
                  for (int tst = 2; tst <= wl + 2; tst++)
                     run_scen(w, fm[0], (li == 0) ? 1 : 3, tst, art[0]);
               end

      // R8: retry of ungranted request; later grant ignored (R2)
      fast_mode = 0; win_ofs = 4'd3; burst_len = 3'd2;
      for (int t = 0; t <= 7; t++) begin
         @(negedge clk);
         if (t == 3) chk("R8 no early withdraw", req_withdrawn, 0);
         if (t == 4) chk("R8 withdraw pulse", req_withdrawn, 1);
         if (t == 6) chk("R8 R2 grant after withdraw", bus_busy, 0);
         if (t == 7) chk("R2 grant idle", bus_busy, 0);
         idle_in();
         tstart = (t == 0); aretry = (t == 3); dgrant = (t == 5 || t == 6);
      end
      idle_in();

      // R11: newer address retried while older tenure streams
      win_ofs = 4'd2; burst_len = 3'd4;
      for (int t = 0; t <= 14; t++) begin
         @(negedge clk);
         if (t == 6) chk("R11 withdraw newer", req_withdrawn, 1);
         if (t == 6) chk("R11 no cancel", beat_cancel, 0);
         if (t == 8) chk("R11 older commit", commit_cnt, 2);
         if (t == 11) chk("R11 busy held", bus_busy, 1);
         if (t == 12) chk("R11 older done", bus_busy, 0);
         if (t == 12) chk("R11 full count", commit_cnt, 4);
         if (t == 14) chk("R11 newer gone", bus_busy, 0);
         idle_in();
         tstart = (t == 0 || t == 3); dgrant = (t == 1 || t == 13);
         xack = (t == 4 || t == 6 || t == 8 || t == 10);
         aretry = (t == 5);
      end
      idle_in();

      // R12: data retry drops a beat and extends the tenure
      burst_len = 3'd2;
      for (int t = 0; t <= 10; t++) begin
         @(negedge clk);
         if (t == 5) chk("R12 beat accepted", beat_acc, 1);
         if (t == 6) chk("R12 dropped beat", beat_commit, 0);
         if (t == 6) chk("R12 no cancel", beat_cancel, 0);
         if (t == 7) chk("R12 cnt after drop", commit_cnt, 0);
         if (t == 8) chk("R12 cnt one", commit_cnt, 1);
         if (t == 8) chk("R12 busy extended", bus_busy, 1);
         if (t == 9) chk("R12 cnt two", commit_cnt, 2);
         if (t == 9) chk("R12 done", bus_busy, 0);
         idle_in();
         tstart = (t == 0); dgrant = (t == 1);
         xack = (t == 4 || t == 6 || t == 7);
         dretry = (t == 5);
      end
      idle_in();

      // R3 + R13: length 0 acts as 1, extra and idle acknowledges ignored
      burst_len = 3'd0;
      for (int t = 0; t <= 8; t++) begin
         @(negedge clk);
         if (t == 2) chk("R3 ack while idle", beat_acc, 0);
         if (t == 5) chk("R3 first beat", beat_acc, 1);
         if (t == 6) chk("R3 R13 extra ignored", beat_acc, 0);
         if (t == 6) chk("R13 len0 done", bus_busy, 0);
         if (t == 7) chk("R13 len0 count", commit_cnt, 1);
         idle_in();
         tstart = (t == 0); dgrant = (t == 1);
         xack = (t == 1 || t == 4 || t == 5);
      end
      idle_in();

      // R13: length above the maximum acts as the maximum
      burst_len = 3'd7;
      for (int t = 0; t <= 12; t++) begin
         @(negedge clk);
         if (t == 8) chk("R13 len clamp busy", bus_busy, 1);
         if (t == 9) chk("R13 len clamp done", bus_busy, 0);
         if (t == 9) chk("R13 len clamp count", commit_cnt, 4);
         if (t == 9) chk("R13 len clamp ignore", beat_acc, 0);
         idle_in();
         tstart = (t == 0); dgrant = (t == 1);
         xack = (t >= 4 && t <= 8);
      end
      idle_in();

      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule